// File: doc/BRIEF.md
# Zero-Wait Host Read Bridge

This block sits between a host processor with a narrow data bus (8 or 16 bits, chosen by an input) and a 32-bit internal shared memory. It turns each host read strobe into memory fetches and presents the requested byte or halfword on the host data bus.

Two read disciplines are supported. In zero-wait mode the host never sees wait states. A read whose word address is not held in the bridge's holding latch is a dummy read: it returns zero and starts a 32-bit fetch into the latch. Later reads inside that word are served from the latch in the next clock, one slice per read. In stalled mode every read goes to memory, and `host_ready` is pulled low until the data is present.

The memory answers with a fixed latency of two clocks. The controller is a five-state machine:
- `ST_IDLE` accepts reads.
- `ST_FREQ` then `ST_FWAIT` perform a zero-wait fill.
- `ST_SREQ` then `ST_SWAIT` perform a stalled read.

The transitions are:
- `ST_IDLE`→`ST_IDLE` on a latch hit in zero-wait mode.
- `ST_IDLE`→`ST_FREQ` on a zero-wait miss.
- `ST_IDLE`→`ST_SREQ` on any read in stalled mode.
- `ST_FREQ`→`ST_FWAIT`→`ST_IDLE`.
- `ST_SREQ`→`ST_SWAIT`→`ST_IDLE`.

Top module: `zw_host_bridge`

## Requirements
- R1: After reset `host_ready` is 1, `host_rdata` is 0, `mem_req` is 0, and the latch holds no valid word, so the first zero-wait read is a dummy read.
- R2: In zero-wait mode, a read to a word address not held in the latch returns `host_rdata` = 0 in the next clock. It raises `mem_req` for exactly one clock with `mem_addr` = `host_addr[7:2]`.
- R3: The latch captures `mem_rdata` at the end of the second clock after `mem_req` rises. `mem_addr` stays stable over that window. In zero-wait mode `host_ready` stays 1.
- R4: With `bus16` = 0, `host_addr[1:0]` selects the byte of the 32-bit word, where byte 0 is bits 7:0. The byte appears on `host_rdata[7:0]`, and `host_rdata[15:8]` is 0.
- R5: With `bus16` = 1, `host_addr[1]` selects the halfword (0 = bits 15:0, 1 = bits 31:16), and `host_addr[0]` is ignored.
- R6: In zero-wait mode, a read whose word address matches the latched one returns its slice in the next clock and raises no `mem_req`.
- R7: Reading a full 32-bit word over the 8-bit bus in zero-wait mode takes five host reads: one dummy read and four data reads.
- R8: A zero-wait read to a word address other than the latched one is a new dummy read and reloads the latch.
- R9: With `zw_mode` = 0, every accepted read raises `mem_req` and drops `host_ready` for exactly two clocks, even when the latch matches. When `host_ready` returns to 1, `host_rdata` holds the requested slice.
- R10: A `host_rd` that arrives while a fetch is in progress is ignored. It produces no new `mem_req` and leaves `host_rdata` unchanged.
- R11: A stalled-mode read also loads the latch, so a later zero-wait read in that word is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus16 | input | 1 | 1 = 16-bit host bus, 0 = 8-bit host bus |
| zw_mode | input | 1 | 1 = zero-wait reads, 0 = stalled reads |
| host_rd | input | 1 | One-clock host read strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_rdata | output | 16 | Read data (8-bit bus uses bits 7:0) |
| host_ready | output | 1 | 0 while a stalled read waits for memory |
| mem_req | output | 1 | One-clock memory fetch request |
| mem_addr | output | ADDR_W-2 | Word address of the fetch |
| mem_rdata | input | 32 | Memory data, valid two clocks after the request |

## Verification
The hardest situation to reach is a host read that lands while a zero-wait fill is still in flight. At the ports this looks exactly like a normal read, and it must be dropped without corrupting the latch. The bench issues a dummy read and then, on the very next clock, strobes another read to the same word. It checks that no second request and no data change occur, and then confirms that a later read still hits the word that was filled. The switch from stalled to zero-wait mode is also set up in the vector table, to show that a stalled read leaves a usable latch behind.

// File: rtl/zw_pkg.sv
package zw_pkg;
    localparam int MEM_W  = 32;
    localparam int HOST_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FREQ  = 3'd1,
        ST_FWAIT = 3'd2,
        ST_SREQ  = 3'd3,
        ST_SWAIT = 3'd4
    } zw_state_t;
endpackage

// File: rtl/zw_tag.sv
module zw_tag #(
    parameter int WORD_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [WORD_W-1:0]        load_word,
    input  logic [zw_pkg::MEM_W-1:0] load_data,
    input  logic [WORD_W-1:0]        query_word,
    output logic [zw_pkg::MEM_W-1:0] data,
    output logic                     hit
);
    logic              valid_q;
    logic [WORD_W-1:0] tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            data    <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            tag_q   <= load_word;
            data    <= load_data;
        end
    end

    assign hit = valid_q && (tag_q == query_word);
endmodule

// File: rtl/zw_slice.sv
module zw_slice (
    input  logic [zw_pkg::MEM_W-1:0]  word,
    input  logic [1:0]                sel,
    input  logic                      bus16,
    output logic [zw_pkg::HOST_W-1:0] out
);
    always_comb begin
        if (bus16) begin
            out = sel[1] ? word[31:16] : word[15:0];
        end else begin
            unique case (sel)
                2'd0: out = {8'h00, word[7:0]};
                2'd1: out = {8'h00, word[15:8]};
                2'd2: out = {8'h00, word[23:16]};
                2'd3: out = {8'h00, word[31:24]};
            endcase
        end
    end
endmodule

// File: rtl/zw_ctrl.sv
module zw_ctrl
    import zw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  logic      zw_mode,
    input  logic      hit,
    output zw_state_t state,
    output logic      mem_req,
    output logic      capture,
    output logic      deliver,
    output logic      ready
);
    zw_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!zw_mode)  nxt = ST_SREQ;
                    else if (!hit) nxt = ST_FREQ;
                end
            end
            ST_FREQ:  nxt = ST_FWAIT;
            ST_FWAIT: nxt = ST_IDLE;
            ST_SREQ:  nxt = ST_SWAIT;
            ST_SWAIT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        mem_req = 1'b0;
        capture = 1'b0;
        deliver = 1'b0;
        ready   = 1'b1;
        unique case (state)
            ST_IDLE:  ;
            ST_FREQ:  mem_req = 1'b1;
            ST_FWAIT: capture = 1'b1;
            ST_SREQ: begin
                mem_req = 1'b1;
                ready   = 1'b0;
            end
            ST_SWAIT: begin
                capture = 1'b1;
                deliver = 1'b1;
                ready   = 1'b0;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/zw_host_bridge.sv
module zw_host_bridge
    import zw_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus16,
    input  logic              zw_mode,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [HOST_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [MEM_W-1:0]  mem_rdata
);
    zw_state_t         state;
    logic              hit, accept, capture, deliver;
    logic [ADDR_W-1:0] req_addr_q;
    logic [MEM_W-1:0]  latch_data;
    logic [HOST_W-1:0] hit_slice, mem_slice;

    assign accept = host_rd && (state == ST_IDLE);

    zw_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .zw_mode (zw_mode),
        .hit     (hit),
        .state   (state),
        .mem_req (mem_req),
        .capture (capture),
        .deliver (deliver),
        .ready   (host_ready)
    );

    zw_tag #(.WORD_W(WORD_W)) u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (capture),
        .load_word  (req_addr_q[ADDR_W-1:2]),
        .load_data  (mem_rdata),
        .query_word (host_addr[ADDR_W-1:2]),
        .data       (latch_data),
        .hit        (hit)
    );

    zw_slice u_hit_slice (
        .word  (latch_data),
        .sel   (host_addr[1:0]),
        .bus16 (bus16),
        .out   (hit_slice)
    );

    zw_slice u_mem_slice (
        .word  (mem_rdata),
        .sel   (req_addr_q[1:0]),
        .bus16 (bus16),
        .out   (mem_slice)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q <= '0;
        end else if (accept && !(zw_mode && hit)) begin
            req_addr_q <= host_addr;
        end
    end

    assign mem_addr = req_addr_q[ADDR_W-1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (accept && zw_mode) begin
            host_rdata <= hit ? hit_slice : '0;
        end else if (deliver) begin
            host_rdata <= mem_slice;
        end
    end
endmodule

// File: rtl/zw_host_bridge_chk.sv
module zw_host_bridge_chk
    import zw_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              zw_mode,
    input logic              host_rd,
    input logic              host_ready,
    input logic [HOST_W-1:0] host_rdata,
    input logic              mem_req,
    input logic [WORD_W-1:0] mem_addr,
    input zw_state_t         state,
    input logic              hit
);
    // R2
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3
    mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> $stable(mem_addr));

    // R9
    ready_fall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ready) |-> mem_req);

    // R9
    ready_two_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ready) |=> !host_ready);

    // R9
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ready) |-> ##2 host_ready);

    // R2
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && zw_mode && state == ST_IDLE && !hit) |=> (host_rdata == '0 && mem_req));

    // R6
    hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && zw_mode && state == ST_IDLE && hit) |=> !mem_req);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (state == ST_FREQ || state == ST_FWAIT)) |=> $stable(host_rdata));
endmodule

bind zw_host_bridge zw_host_bridge_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .zw_mode    (zw_mode),
    .host_rd    (host_rd),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .state      (state),
    .hit        (hit)
);

// File: tb/zw_host_bridge_test.sv
module zw_host_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus16 = 1'b0;
    logic        zw_mode = 1'b1;
    logic        host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_rdata;
    logic        host_ready;
    logic        mem_req;
    logic [5:0]  mem_addr;
    logic [31:0] mem_rdata;
    logic [5:0]  mem_q = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zw_host_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus16(bus16), .zw_mode(zw_mode),
        .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata),
        .host_ready(host_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    // memory model: byte at byte address a holds a ^ 8'h5A; two-clock latency
    always_ff @(posedge clk) if (mem_req) mem_q <= mem_addr;
    always_comb begin
        for (int i = 0; i < 4; i++)
            mem_rdata[8*i +: 8] = {mem_q, 2'(i)} ^ 8'h5A;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 hit, 1 dummy, 2 stalled; fields {kind, bus16, zw, addr, expected}
    localparam logic [27:0] VEC [0:13] = '{
        {2'd1, 1'b0, 1'b1, 8'h14, 16'h0000},  // R1 R7 first read is dummy
        {2'd0, 1'b0, 1'b1, 8'h14, 16'h004E},  // R4 R7
        {2'd0, 1'b0, 1'b1, 8'h15, 16'h004F},
        {2'd0, 1'b0, 1'b1, 8'h16, 16'h004C},
        {2'd0, 1'b0, 1'b1, 8'h17, 16'h004D},  // R7 fifth read
        {2'd0, 1'b1, 1'b1, 8'h16, 16'h4D4C},  // R5
        {2'd0, 1'b1, 1'b1, 8'h14, 16'h4F4E},
        {2'd0, 1'b1, 1'b1, 8'h15, 16'h4F4E},  // R5 addr bit 0 ignored
        {2'd1, 1'b1, 1'b1, 8'h20, 16'h0000},  // R8 new word
        {2'd0, 1'b1, 1'b1, 8'h22, 16'h7978},
        {2'd0, 1'b0, 1'b1, 8'h21, 16'h007B},
        {2'd2, 1'b0, 1'b0, 8'h30, 16'h006A},  // R9
        {2'd2, 1'b1, 1'b0, 8'h32, 16'h6968},  // R9 same word still stalls
        {2'd0, 1'b0, 1'b1, 8'h31, 16'h006B}   // R11
    };

    task automatic do_read(input logic [1:0] kind, input logic b16, input logic zw,
                           input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus16 = b16; zw_mode = zw; host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        if (kind == 2'd0) begin
            check("R6 hit data", 32'(host_rdata), 32'(exp));
            check("R6 no mem_req", 32'(mem_req), 32'd0);
        end else if (kind == 2'd1) begin
            check("R2 dummy data", 32'(host_rdata), 32'(exp));
            check("R2 mem_req", 32'(mem_req), 32'd1);
            check("R2 mem_addr", 32'(mem_addr), 32'(a[7:2]));
            check("R3 ready high", 32'(host_ready), 32'd1);
            @(negedge clk);
        end else begin
            check("R9 ready low 1", 32'(host_ready), 32'd0);
            check("R9 mem_req", 32'(mem_req), 32'd1);
            @(negedge clk);
            check("R9 ready low 2", 32'(host_ready), 32'd0);
            @(negedge clk);
            check("R9 ready back", 32'(host_ready), 32'd1);
            check("R9 data", 32'(host_rdata), 32'(exp));
        end
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", 32'(host_ready), 32'd1);
        check("R1 rdata", 32'(host_rdata), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);

        for (int i = 0; i < 14; i++) begin
            do_read(VEC[i][27:26], VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:0]);
        end

        // R10: read arriving during a fill is dropped
        @(negedge clk);
        bus16 = 1'b0; zw_mode = 1'b1; host_rd = 1'b1; host_addr = 8'h08;
        @(negedge clk);
        host_addr = 8'h09;
        @(negedge clk);
        host_rd = 1'b0;
        check("R10 no new mem_req", 32'(mem_req), 32'd0);
        check("R10 rdata unchanged", 32'(host_rdata), 32'd0);
        @(negedge clk);
        check("R10 no late mem_req", 32'(mem_req), 32'd0);
        do_read(2'd0, 1'b0, 1'b1, 8'h0A, 16'h0050);  // R3 latch filled

        // R8: return to a prior word needs a new dummy
        do_read(2'd1, 1'b0, 1'b1, 8'h14, 16'h0000);
        do_read(2'd0, 1'b0, 1'b1, 8'h17, 16'h004D);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule